// File: doc/BRIEF.md
# Mode-Switchable Data Cache Controller

This block sits between a CPU load/store port and a word-wide external memory port. It caches 32-byte lines of eight 32-bit words. After reset the storage is organised as a direct-mapped cache that uses one bank of line slots. A configuration bit turns the same two banks into a two-way set-associative cache, in which each set keeps one least-recently-used bit to choose the replacement victim. A second configuration bit selects write-through instead of copy-back.

A third bit reserves the upper half of the set slots as plain on-chip memory. That memory serves the upper half of the address space, and the cache shrinks to the lower half of the sets. Configuration is written with a load strobe. Software must run a full invalidate before it changes the organisation. The invalidate sweeps one set per cycle.

The CPU holds its request until `cpu_ready` pulses. The external memory sees one word transfer at a time under a request/acknowledge handshake.

Top module: `dc_ctrl`

## Requirements
- R1: After reset, `cpu_ready`, `mem_req` and `inv_busy` are low, and the block runs direct-mapped, copy-back, with no RAM region.
- R2: A read hit raises `cpu_ready` for exactly one cycle, one cycle after the request, with no external memory transfer.
- R3: A read miss fetches the whole line as 8 word reads, at addresses `{addr[AW-1:3], 0..7}`, before it answers with the requested word.
- R4: In direct-mapped mode, two lines whose word addresses agree in bits [6:3] (default 16 sets) but differ above them evict each other.
- R5: In copy-back mode, a write (hit, or miss after allocation) causes no external write. Evicting a dirty line writes all 8 of its words to memory before the new line is fetched.
- R6: In two-way mode, two lines with the same set index stay resident together and hit with no memory traffic.
- R7: In two-way mode, a miss replaces the least-recently-used way of the set. Every hit or fill marks the other way as least recent.
- R8: In write-through mode, a write hit updates the line and performs exactly one memory write. The line never becomes dirty, so evicting it writes nothing.
- R9: In write-through mode, a write miss performs one memory write and allocates no line.
- R10: In RAM mode, accesses with address bit AW-1 set are served on chip in one cycle with no memory transfer. In two-way mode address bit 6 selects the bank, which gives 128 distinct words.
- R11: In RAM mode with direct mapping, address bit 6 is ignored inside the RAM region, so addresses that differ only there alias.
- R12: An invalidate raises `inv_busy` for exactly SETS cycles. After it, every line misses.
- R13: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the three configuration bits |
| cfg_two_way | input | 1 | 1: two-way LRU, 0: direct-mapped |
| cfg_wthru | input | 1 | 1: write-through, 0: copy-back |
| cfg_ram | input | 1 | 1: upper half of sets used as on-chip RAM |
| inv_req | input | 1 | Starts a full invalidate |
| inv_busy | output | 1 | Invalidate sweep in progress |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | CPU write |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | External transfer request |
| mem_we | output | 1 | External write |
| mem_addr | output | AW | External word address |
| mem_wdata | output | DW | External write data |
| mem_rdata | input | DW | External read data, valid with ack |
| mem_ack | input | 1 | External transfer done |

## Verification
A stale valid bit or tag shows up at the ports within one access. A hit that should have been a miss returns wrong data with a one-cycle ready. A miss that should have been a hit shows eight unexpected external reads. A wrong LRU bit only appears on the third distinct line mapped to one set, and then as a miss on the line that should have stayed resident. A wrong dirty bit stays hidden until eviction, where the count of external writes is zero or eight when it should be the other. The bench therefore counts transfers and checks memory contents after every eviction.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_WT} dc_state_e;

  typedef struct packed {
    logic two_way;
    logic wthru;
    logic ram;
  } dc_cfg_t;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS = 16,
  parameter int TW   = 10,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_set,
  output logic [TW-1:0] tag0_o,
  output logic [TW-1:0] tag1_o,
  output logic [1:0]    vld_o,
  output logic [1:0]    dty_o,
  output logic          lru_o,
  input  logic          fill_we,
  input  logic          fill_way,
  input  logic [IW-1:0] fill_set,
  input  logic [TW-1:0] fill_tag,
  input  logic          dirty_we,
  input  logic          dirty_way,
  input  logic [IW-1:0] dirty_set,
  input  logic          lru_we,
  input  logic [IW-1:0] lru_set,
  input  logic          lru_val,
  input  logic          inv_req,
  output logic          busy_o
);
  logic [TW-1:0]   tag_q [2][SETS];
  logic [SETS-1:0] vld_q [2];
  logic [SETS-1:0] vld_d [2];
  logic [SETS-1:0] dty_q [2];
  logic [SETS-1:0] dty_d [2];
  logic [SETS-1:0] lru_q, lru_d;
  logic            busy_q, busy_d;
  logic [IW-1:0]   icnt_q, icnt_d;

  always_comb begin
    vld_d  = vld_q;
    dty_d  = dty_q;
    lru_d  = lru_q;
    busy_d = busy_q;
    icnt_d = icnt_q;
    if (busy_q) begin
      vld_d[0][icnt_q] = 1'b0;
      vld_d[1][icnt_q] = 1'b0;
      dty_d[0][icnt_q] = 1'b0;
      dty_d[1][icnt_q] = 1'b0;
      lru_d[icnt_q]    = 1'b0;
      icnt_d           = icnt_q + 1'b1;
      if (icnt_q == IW'(SETS - 1)) busy_d = 1'b0;
    end else begin
      if (inv_req) begin
        busy_d = 1'b1;
        icnt_d = '0;
      end
      if (fill_we) begin
        vld_d[fill_way][fill_set] = 1'b1;
        dty_d[fill_way][fill_set] = 1'b0;
      end
      if (dirty_we) dty_d[dirty_way][dirty_set] = 1'b1;
      if (lru_we)   lru_d[lru_set] = lru_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      dty_q[0] <= '0;
      dty_q[1] <= '0;
      lru_q    <= '0;
      busy_q   <= 1'b0;
      icnt_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      dty_q  <= dty_d;
      lru_q  <= lru_d;
      busy_q <= busy_d;
      icnt_q <= icnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we && !busy_q) tag_q[fill_way][fill_set] <= fill_tag;
  end

  assign tag0_o = tag_q[0][rd_set];
  assign tag1_o = tag_q[1][rd_set];
  assign vld_o  = {vld_q[1][rd_set], vld_q[0][rd_set]};
  assign dty_o  = {dty_q[1][rd_set], dty_q[0][rd_set]};
  assign lru_o  = lru_q[rd_set];
  assign busy_o = busy_q;

  logic [IW:0] bcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcnt_q <= '0;
    else if (!busy_q) bcnt_q <= '0;
    else              bcnt_q <= bcnt_q + 1'b1;
  end

  // R12
  inv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bcnt_q < (IW+1)'(SETS)));
  // R12
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (vld_q[0] == '0 && vld_q[1] == '0));
  // R5
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dty_o & ~vld_o) == 2'b00);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int DAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [DAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [DAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dc_ctrl_fsm.sv
module dc_ctrl_fsm
  import dc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SETS = 16,
  localparam int OW  = 3,
  localparam int IW  = $clog2(SETS),
  localparam int TW  = AW - OW - (IW - 1),
  localparam int DAW = 1 + IW + OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  dc_cfg_t        cfg,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic [IW-1:0]  rd_set,
  input  logic [TW-1:0]  tag0_i,
  input  logic [TW-1:0]  tag1_i,
  input  logic [1:0]     vld_i,
  input  logic [1:0]     dty_i,
  input  logic           lru_i,
  input  logic           busy_i,
  output logic           fill_we,
  output logic           fill_way,
  output logic [TW-1:0]  fill_tag,
  output logic           dirty_we,
  output logic           dirty_way,
  output logic           lru_we,
  output logic           lru_val,
  output logic           ds_we,
  output logic [DAW-1:0] ds_waddr,
  output logic [DW-1:0]  ds_wdata,
  output logic [DAW-1:0] ds_raddr,
  input  logic [DW-1:0]  ds_rdata
);
  localparam logic [OW-1:0] LAST = '1;

  dc_state_e     st_q, st_d;
  logic [OW-1:0] cnt_q, cnt_d;
  logic          vway_q, vway_d;
  logic [TW-1:0] vtag_q, vtag_d;
  logic          ready_q, ready_d;
  logic [DW-1:0] rdata_q, rdata_d;

  logic [OW-1:0]  word;
  logic [IW-1:0]  set;
  logic [TW-1:0]  tag;
  logic           in_ram, hit0, hit1, hit, go, vw;
  logic [DAW-1:0] ram_idx, hit_idx;

  assign word    = cpu_addr[OW-1:0];
  assign set     = {cfg.ram ? 1'b0 : cpu_addr[OW+IW-1], cpu_addr[OW+IW-2:OW]};
  assign tag     = cpu_addr[AW-1:OW+IW-1];
  assign in_ram  = cfg.ram & cpu_addr[AW-1];
  assign ram_idx = {cfg.two_way & cpu_addr[OW+IW-1], 1'b1, cpu_addr[OW+IW-2:0]};
  assign hit0    = vld_i[0] & (tag0_i == tag);
  assign hit1    = cfg.two_way & vld_i[1] & (tag1_i == tag);
  assign hit     = hit0 | hit1;
  assign hit_idx = {hit1, set, word};
  assign vw      = cfg.two_way & lru_i;
  assign go      = cpu_req & ~ready_q & ~busy_i;
  assign rd_set  = set;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; vway_d = vway_q; vtag_d = vtag_q;
    ready_d = 1'b0; rdata_d = rdata_q;
    fill_we = 1'b0; fill_way = vway_q; fill_tag = tag;
    dirty_we = 1'b0; dirty_way = hit1;
    lru_we = 1'b0; lru_val = ~hit1;
    ds_we = 1'b0; ds_waddr = hit_idx; ds_wdata = cpu_wdata;
    ds_raddr = in_ram ? ram_idx : hit_idx;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cpu_addr; mem_wdata = cpu_wdata;
    unique case (st_q)
      ST_IDLE: if (go) begin
        if (in_ram) begin
          ready_d = 1'b1;
          ds_waddr = ram_idx;
          ds_we = cpu_we;
          if (!cpu_we) rdata_d = ds_rdata;
        end else if (hit) begin
          lru_we = cfg.two_way;
          if (cpu_we) begin
            ds_we = 1'b1;
            if (cfg.wthru) st_d = ST_WT;
            else begin
              dirty_we = 1'b1;
              ready_d  = 1'b1;
            end
          end else begin
            rdata_d = ds_rdata;
            ready_d = 1'b1;
          end
        end else if (cpu_we && cfg.wthru) begin
          st_d = ST_WT;
        end else begin
          vway_d = vw;
          vtag_d = vw ? tag1_i : tag0_i;
          cnt_d  = '0;
          st_d   = (vld_i[vw] && dty_i[vw]) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        ds_raddr  = {vway_q, set, cnt_q};
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vtag_q, set[IW-2:0], cnt_q};
        mem_wdata = ds_rdata;
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {cpu_addr[AW-1:OW], cnt_q};
        if (mem_ack) begin
          ds_we    = 1'b1;
          ds_waddr = {vway_q, set, cnt_q};
          ds_wdata = mem_rdata;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            fill_we = 1'b1;
            lru_we  = cfg.two_way;
            lru_val = ~vway_q;
            st_d    = ST_IDLE;
          end
        end
      end
      ST_WT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          ready_d = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; vway_q <= 1'b0; vtag_q <= '0;
      ready_q <= 1'b0; rdata_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; vway_q <= vway_d; vtag_q <= vtag_d;
      ready_q <= ready_d; rdata_q <= rdata_d;
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R10
  ram_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && go && in_ram) |=> (!mem_req && cpu_ready));
  // R7
  lru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && mem_ack && cnt_q == LAST && cfg.two_way) |=> (lru_i == !$past(vway_q)));
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SETS = 16,
  localparam int OW  = 3,
  localparam int IW  = $clog2(SETS),
  localparam int TW  = AW - OW - (IW - 1),
  localparam int DAW = 1 + IW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_two_way,
  input  logic          cfg_wthru,
  input  logic          cfg_ram,
  input  logic          inv_req,
  output logic          inv_busy,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  dc_cfg_t cfg_q, cfg_d;
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_load) cfg_d = '{two_way: cfg_two_way, wthru: cfg_wthru, ram: cfg_ram};
  end
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  logic [IW-1:0]  rd_set;
  logic [TW-1:0]  tag0, tag1, fill_tag;
  logic [1:0]     vld, dty;
  logic           lru, fill_we, fill_way, dirty_we, dirty_way, lru_we, lru_val;
  logic           ds_we;
  logic [DAW-1:0] ds_waddr, ds_raddr;
  logic [DW-1:0]  ds_wdata, ds_rdata;

  dc_tag_store #(.SETS(SETS), .TW(TW)) u_tags (
    .clk(clk), .rst_n(srst_n), .rd_set(rd_set),
    .tag0_o(tag0), .tag1_o(tag1), .vld_o(vld), .dty_o(dty), .lru_o(lru),
    .fill_we(fill_we), .fill_way(fill_way), .fill_set(rd_set), .fill_tag(fill_tag),
    .dirty_we(dirty_we), .dirty_way(dirty_way), .dirty_set(rd_set),
    .lru_we(lru_we), .lru_set(rd_set), .lru_val(lru_val),
    .inv_req(inv_req), .busy_o(inv_busy)
  );

  dc_data_store #(.DEPTH(2 ** DAW), .DW(DW)) u_data (
    .clk(clk), .we(ds_we), .waddr(ds_waddr), .wdata(ds_wdata),
    .raddr(ds_raddr), .rdata(ds_rdata)
  );

  dc_ctrl_fsm #(.AW(AW), .DW(DW), .SETS(SETS)) u_fsm (
    .clk(clk), .rst_n(srst_n), .cfg(cfg_q),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rd_set(rd_set), .tag0_i(tag0), .tag1_i(tag1), .vld_i(vld), .dty_i(dty),
    .lru_i(lru), .busy_i(inv_busy),
    .fill_we(fill_we), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_we(dirty_we), .dirty_way(dirty_way), .lru_we(lru_we), .lru_val(lru_val),
    .ds_we(ds_we), .ds_waddr(ds_waddr), .ds_wdata(ds_wdata),
    .ds_raddr(ds_raddr), .ds_rdata(ds_rdata)
  );
endmodule

// File: tb/tb_dc_ctrl.sv
module tb_dc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SETS = 16;

  logic clk, rst_n;
  logic cfg_load, cfg_two_way, cfg_wthru, cfg_ram, inv_req, inv_busy;
  logic cpu_req, cpu_we, cpu_ready;
  logic [AW-1:0] cpu_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ack;

  int nchk = 0, nerr = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [DW-1:0] wmem [int];

  dc_ctrl #(.AW(AW), .DW(DW), .SETS(SETS)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return wmem.exists(int'(a)) ? wmem[int'(a)] : init_val(a);
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wmem[int'(mem_addr)] = mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= memval(mem_addr);
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 2000);
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic invalidate(output int busy_cyc);
    @(negedge clk); inv_req = 1'b1;
    @(negedge clk); inv_req = 1'b0;
    busy_cyc = 0;
    while (inv_busy && busy_cyc < 1000) begin
      busy_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic tw, input logic wt, input logic rm);
    int bc;
    invalidate(bc);
    @(negedge clk); cfg_load = 1'b1; cfg_two_way = tw; cfg_wthru = wt; cfg_ram = rm;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, cpu_ready}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 busy", {31'd0, inv_busy}, 0);
  endtask

  task automatic t_dm_fill_hit;
    logic [DW-1:0] d; int c, r0;
    r0 = rd_cnt; access(0, 16'h0013, 0, d, c);
    chk("R3 miss data", d, init_val(16'h0013));
    chk("R3 eight reads", rd_cnt - r0, 8);
    r0 = rd_cnt; access(0, 16'h0015, 0, d, c);
    chk("R2 hit data", d, init_val(16'h0015));
    chk("R2 hit latency", c, 1);
    chk("R2 no traffic", rd_cnt - r0, 0);
    // R4: 0x0093 shares set 2 with 0x0013 in direct-mapped mode
    access(0, 16'h0093, 0, d, c);
    r0 = rd_cnt; access(0, 16'h0013, 0, d, c);
    chk("R4 conflict evicts", rd_cnt - r0, 8);
    chk("R4 data", d, init_val(16'h0013));
  endtask

  task automatic t_copyback;
    logic [DW-1:0] d; int c, w0, r0;
    set_cfg(0, 0, 0);
    w0 = wr_cnt; access(1, 16'h0021, 32'hDEAD0001, d, c);
    access(0, 16'h0021, 0, d, c);
    chk("R5 write hit data", d, 32'hDEAD0001);
    chk("R5 no external write", wr_cnt - w0, 0);
    w0 = wr_cnt; r0 = rd_cnt; access(0, 16'h00A1, 0, d, c);
    chk("R5 writeback count", wr_cnt - w0, 8);
    chk("R5 refill count", rd_cnt - r0, 8);
    chk("R5 memory word", memval(16'h0021), 32'hDEAD0001);
    chk("R5 memory neighbour", memval(16'h0020), init_val(16'h0020));
    chk("R5 new data", d, init_val(16'h00A1));
  endtask

  task automatic t_two_way_lru;
    logic [DW-1:0] d; int c, r0;
    set_cfg(1, 0, 0);
    access(0, 16'h0030, 0, d, c);
    access(0, 16'h00B0, 0, d, c);
    r0 = rd_cnt;
    access(0, 16'h0030, 0, d, c);
    chk("R6 line A resident", d, init_val(16'h0030));
    access(0, 16'h00B0, 0, d, c);
    chk("R6 line B resident", d, init_val(16'h00B0));
    chk("R6 no traffic", rd_cnt - r0, 0);
    access(0, 16'h0030, 0, d, c);
    access(0, 16'h0130, 0, d, c);
    chk("R7 third line data", d, init_val(16'h0130));
    r0 = rd_cnt; access(0, 16'h0030, 0, d, c);
    chk("R7 recent line kept", rd_cnt - r0, 0);
    r0 = rd_cnt; access(0, 16'h00B0, 0, d, c);
    chk("R7 LRU line evicted", rd_cnt - r0, 8);
  endtask

  task automatic t_write_through;
    logic [DW-1:0] d; int c, w0, r0;
    set_cfg(0, 1, 0);
    access(0, 16'h0040, 0, d, c);
    w0 = wr_cnt; r0 = rd_cnt; access(1, 16'h0041, 32'h11112222, d, c);
    chk("R8 one write", wr_cnt - w0, 1);
    chk("R8 no read", rd_cnt - r0, 0);
    chk("R8 memory", memval(16'h0041), 32'h11112222);
    access(0, 16'h0041, 0, d, c);
    chk("R8 line updated", d, 32'h11112222);
    w0 = wr_cnt; access(0, 16'h00C1, 0, d, c);
    chk("R8 clean eviction", wr_cnt - w0, 0);
    w0 = wr_cnt; r0 = rd_cnt; access(1, 16'h0051, 32'h33334444, d, c);
    chk("R9 one write", wr_cnt - w0, 1);
    chk("R9 no fill", rd_cnt - r0, 0);
    r0 = rd_cnt; access(0, 16'h0051, 0, d, c);
    chk("R9 not allocated", rd_cnt - r0, 8);
    chk("R9 data", d, 32'h33334444);
  endtask

  task automatic t_ram;
    logic [DW-1:0] d; int c, w0, r0;
    set_cfg(1, 0, 1);
    w0 = wr_cnt; r0 = rd_cnt;
    access(1, 16'h8005, 32'hAAAA0005, d, c);
    chk("R10 write latency", c, 1);
    access(1, 16'h8045, 32'hBBBB0045, d, c);
    access(0, 16'h8005, 0, d, c);
    chk("R10 word a", d, 32'hAAAA0005);
    chk("R10 read latency", c, 1);
    access(0, 16'h8045, 0, d, c);
    chk("R10 word b other bank", d, 32'hBBBB0045);
    chk("R10 no traffic", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk("R10 memory untouched", memval(16'h8005), init_val(16'h8005));
    set_cfg(0, 0, 1);
    access(1, 16'h8045, 32'hCCCC0045, d, c);
    access(0, 16'h8005, 0, d, c);
    chk("R11 alias", d, 32'hCCCC0045);
  endtask

  task automatic t_invalidate;
    logic [DW-1:0] d; int c, r0, bc;
    set_cfg(0, 0, 0);
    access(0, 16'h0060, 0, d, c);
    r0 = rd_cnt; access(0, 16'h0060, 0, d, c);
    chk("R12 resident before", rd_cnt - r0, 0);
    invalidate(bc);
    chk("R12 busy cycles", bc, SETS);
    r0 = rd_cnt; access(0, 16'h0060, 0, d, c);
    chk("R12 miss after", rd_cnt - r0, 8);
    chk("R12 data", d, init_val(16'h0060));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 0; cfg_two_way = 0; cfg_wthru = 0; cfg_ram = 0;
    inv_req = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    mem_ack = 0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_dm_fill_hit;
    t_copyback;
    t_two_way_lru;
    t_write_through;
    t_ram;
    t_invalidate;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule